// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This controller connects a single-beat synchronous host request port to an external pseudo-static RAM of 524,288 bytes. It converts each host read or write into a chip cycle on a 19-bit address bus and an 8-bit data bus. The data bus is split into an output value, an output enable and an input value so that a pad ring can merge them. All chip timing is counted in system clock cycles, and a parameter sets every limit. These limits are the power-up pause, the address setup, the access time, the write pulse, the cycle time, the refresh period, the refresh pulse lengths and the recovery after self refresh.

The memory has one pin that acts both as read output enable and as refresh request. While chip enable is high, a short low pulse on that pin performs one auto refresh. Holding it low for at least a minimum time enters self refresh. The controller runs an interval timer that raises a pending refresh. The state machine serves that refresh from its idle state only, so a refresh never cuts into a chip cycle. While the machine is busy, `req_ready` drops and host requests wait. A level input `sleep_req` moves the memory into self refresh and, when it is released, back out through a recovery wait. The interval timer is frozen for the whole time spent in self refresh.

States: `ST_POWERUP` (initial pause), `ST_IDLE`, `ST_ADDR_SETUP` (address out, chip enable high), `ST_READ` (chip enable and output enable low), `ST_WRITE` (chip enable and read/write low, data driven), `ST_WR_HOLD` (read/write high, data still driven), `ST_PRECHARGE` (chip enable high to fill the cycle time), `ST_REF_PULSE`, `ST_REF_WAIT`, `ST_SELF_ENTER`, `ST_SELF`, `ST_SELF_EXIT`. Transitions:
- `ST_POWERUP` to `ST_IDLE` after the pause.
- `ST_IDLE` to `ST_REF_PULSE` when a refresh is pending. Otherwise to `ST_SELF_ENTER` when sleep is requested. Otherwise to `ST_ADDR_SETUP` on an accepted request.
- `ST_ADDR_SETUP` to `ST_READ` or `ST_WRITE`.
- `ST_READ` to `ST_PRECHARGE`.
- `ST_WRITE` to `ST_WR_HOLD` to `ST_PRECHARGE` to `ST_IDLE`.
- `ST_REF_PULSE` to `ST_REF_WAIT` to `ST_IDLE`.
- `ST_SELF_ENTER` to `ST_SELF` after the minimum low time.
- `ST_SELF` to `ST_SELF_EXIT` when sleep is released.
- `ST_SELF_EXIT` to `ST_IDLE` after the recovery time.

Top module: `psram_ctrl`

## Requirements
- R1: For the first T_POWERUP cycles after reset, `mem_ce_n`, `mem_rw_n` and `mem_oe_rfsh_n` stay high, `mem_dq_oe` stays low and `req_ready` stays low. `req_ready` first rises T_POWERUP cycles after reset is released.
- R2: A read (`req_write`=0) holds the address on `mem_addr` for T_ADDR_SETUP cycles before `mem_ce_n` falls and keeps it unchanged while `mem_ce_n` is low. It then keeps `mem_ce_n` and `mem_oe_rfsh_n` low for T_ACCESS+1 cycles. `mem_dq_in` is sampled at the end of the last of those cycles. The sample is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R3: A write (`req_write`=1) drops `mem_rw_n` only while `mem_ce_n` is low, for T_WR_PULSE cycles. `mem_rw_n` rises one cycle before `mem_ce_n`. `mem_dq_oe` is high and `mem_dq_out` is stable, carrying the request data, across the rising edge of `mem_rw_n`.
- R4: Two falling edges of `mem_ce_n` are at least T_CYCLE cycles apart.
- R5: A refresh becomes pending every T_REFRESH_INTERVAL cycles of running time. It is served as a low pulse on `mem_oe_rfsh_n` of exactly T_AUTO_PULSE cycles, with `mem_ce_n` high throughout.
- R6: A refresh that falls due during a chip cycle waits for that cycle to finish. While a refresh pulse or self refresh is on the pin, `req_ready` is low. A request held during that time is served afterwards with correct data.
- R7: With `sleep_req` high and the machine idle, `mem_oe_rfsh_n` goes low with `mem_ce_n` high. `sleep_active` rises only after at least T_SELF_MIN low cycles. The pin stays low, and `req_ready` stays low, while `sleep_active` is high.
- R8: After `sleep_req` falls, `mem_oe_rfsh_n` returns high and no chip cycle starts for at least T_RECOVER cycles. Data written before sleep then reads back unchanged.
- R9: No auto-refresh pulse is issued while in self refresh. After wake, the interval timer resumes and the next auto refresh follows within T_REFRESH_INTERVAL cycles.
- R10: `mem_dq_oe` is never high while `mem_oe_rfsh_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host byte address |
| req_wdata | input | 8 | Host write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| sleep_req | input | 1 | Level request to stay in self refresh |
| sleep_active | output | 1 | Memory is held in self refresh |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data received from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_rw_n | output | 1 | Read/write strobe, low for write |
| mem_oe_rfsh_n | output | 1 | Shared output enable / refresh request, active low |

## Verification
The properties assume that `req_addr`, `req_write` and `req_wdata` are valid whenever `req_valid` and `req_ready` are both high. They also assume that `sleep_req` is a level which the host holds steady for many cycles, so the machine only sees it in idle or in `ST_SELF`. The bench changes request fields only at falling clock edges and drops `req_valid` right after acceptance. It keeps `sleep_req` high for hundreds of cycles before releasing it. Its memory model returns a garbage byte until T_ACCESS+1 cycles of chip enable have elapsed, so that an early sample shows up as a data mismatch.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_READ,
        ST_WRITE,
        ST_WR_HOLD,
        ST_PRECHARGE,
        ST_REF_PULSE,
        ST_REF_WAIT,
        ST_SELF_ENTER,
        ST_SELF,
        ST_SELF_EXIT
    } psram_state_e;

    function automatic int pmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_delay.sv
// Shared countdown used to time every state of the controller.
module psram_delay #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_refresh_sched.sv
// Interval timer raising a sticky refresh request; freezes while run is low.
module psram_refresh_sched #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pending
);

    localparam int IW = $clog2(INTERVAL + 1);

    logic [IW-1:0] tick_q;
    logic          wrap;

    assign wrap = run && (tick_q == IW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (wrap) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wrap) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/psram_datapath.sv
// Holds the accepted request toward the pins and captures read data.
module psram_datapath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          rd_sample,
    input  logic [DW-1:0] pin_rdata,
    output logic          is_write,
    output logic [AW-1:0] pin_addr,
    output logic [DW-1:0] pin_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_write  <= 1'b0;
            pin_addr  <= '0;
            pin_wdata <= '0;
        end else if (accept) begin
            is_write  <= in_write;
            pin_addr  <= in_addr;
            pin_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_sample;
            if (rd_sample) begin
                rsp_rdata <= pin_rdata;
            end
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int AW                 = 19,
    parameter int DW                 = 8,
    parameter int T_POWERUP          = 10000,
    parameter int T_ADDR_SETUP       = 1,
    parameter int T_ACCESS           = 7,
    parameter int T_CYCLE            = 12,
    parameter int T_WR_PULSE         = 5,
    parameter int T_AUTO_PULSE       = 3,
    parameter int T_REF_GAP          = 12,
    parameter int T_SELF_MIN         = 100,
    parameter int T_RECOVER          = 60,
    parameter int T_REFRESH_INTERVAL = 1560
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          sleep_req,
    output logic          sleep_active,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_ce_n,
    output logic          mem_rw_n,
    output logic          mem_oe_rfsh_n
);

    localparam int RD_LEN = T_ACCESS + 1;
    localparam int RD_PRE = pmax(1, T_CYCLE - RD_LEN);
    localparam int WR_PRE = pmax(1, T_CYCLE - T_WR_PULSE - 1);
    localparam int MAX_A  = pmax(pmax(T_POWERUP, T_SELF_MIN), pmax(T_RECOVER, T_REF_GAP));
    localparam int MAX_B  = pmax(pmax(RD_LEN, RD_PRE), pmax(WR_PRE, T_WR_PULSE));
    localparam int MAX_D  = pmax(pmax(MAX_A, MAX_B), pmax(T_ADDR_SETUP, T_AUTO_PULSE));
    localparam int CW     = $clog2(MAX_D + 1);

    psram_state_e state_q, state_d;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          ref_pending, ref_ack, ref_run;
    logic          accept, rd_sample, cur_write;

    // ---------------- sub-blocks ----------------
    psram_delay #(
        .W       (CW),
        .RST_VAL (T_POWERUP - 1)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_refresh_sched #(
        .INTERVAL (T_REFRESH_INTERVAL)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ref_run),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    psram_datapath #(
        .AW (AW),
        .DW (DW)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .rd_sample (rd_sample),
        .pin_rdata (mem_dq_in),
        .is_write  (cur_write),
        .pin_addr  (mem_addr),
        .pin_wdata (mem_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and timer load ----------------
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_POWERUP: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d  = ST_REF_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_AUTO_PULSE - 1);
                end else if (sleep_req) begin
                    state_d  = ST_SELF_ENTER;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_SELF_MIN - 1);
                end else if (req_valid) begin
                    state_d  = ST_ADDR_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_ADDR_SETUP - 1);
                end
            end
            ST_ADDR_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (cur_write) begin
                        state_d = ST_WRITE;
                        tmr_val = CW'(T_WR_PULSE - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = CW'(RD_LEN - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    state_d  = ST_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RD_PRE - 1);
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = '0;
                end
            end
            ST_WR_HOLD: begin
                state_d  = ST_PRECHARGE;
                tmr_load = 1'b1;
                tmr_val  = CW'(WR_PRE - 1);
            end
            ST_PRECHARGE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_REF_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_REF_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_REF_GAP - 1);
                end
            end
            ST_REF_WAIT: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_SELF_ENTER: begin
                if (tmr_done) state_d = ST_SELF;
            end
            ST_SELF: begin
                if (!sleep_req) begin
                    state_d  = ST_SELF_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_RECOVER - 1);
                end
            end
            ST_SELF_EXIT: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_ce_n      = 1'b1;
        mem_rw_n      = 1'b1;
        mem_oe_rfsh_n = 1'b1;
        mem_dq_oe     = 1'b0;
        sleep_active  = 1'b0;
        ref_ack       = 1'b0;
        ref_run       = 1'b1;
        rd_sample     = 1'b0;
        req_ready     = 1'b0;
        unique case (state_q)
            ST_POWERUP:   ref_run = 1'b0;
            ST_IDLE:      req_ready = !ref_pending && !sleep_req;
            ST_READ: begin
                mem_ce_n      = 1'b0;
                mem_oe_rfsh_n = 1'b0;
                rd_sample     = tmr_done;
            end
            ST_WRITE: begin
                mem_ce_n  = 1'b0;
                mem_rw_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_REF_PULSE: begin
                mem_oe_rfsh_n = 1'b0;
                ref_ack       = 1'b1;
            end
            ST_SELF_ENTER: begin
                mem_oe_rfsh_n = 1'b0;
                ref_run       = 1'b0;
            end
            ST_SELF: begin
                mem_oe_rfsh_n = 1'b0;
                sleep_active  = 1'b1;
                ref_run       = 1'b0;
            end
            ST_SELF_EXIT: ref_run = 1'b0;
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int T_POWERUP = 10000,
    parameter int T_CYCLE   = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          sleep_active,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe,
    input logic          mem_ce_n,
    input logic          mem_rw_n,
    input logic          mem_oe_rfsh_n
);

    int unsigned pu_cnt;
    int unsigned since_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_cnt     <= 0;
            since_fall <= T_CYCLE;
        end else begin
            if (pu_cnt < T_POWERUP) pu_cnt <= pu_cnt + 1;
            if (mem_ce_n == 1'b0 && since_fall == 0) since_fall <= 1;
            else if (since_fall < T_CYCLE) since_fall <= since_fall + 1;
            if ($fell(mem_ce_n)) since_fall <= 1;
        end
    end

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_cnt < T_POWERUP) |-> (mem_ce_n && mem_oe_rfsh_n && !req_ready)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_RW_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rw_n |-> !mem_ce_n); // R3
    AST_WR_DATA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rw_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out))); // R3
    AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (since_fall >= T_CYCLE)); // R4
    AST_REF_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_rfsh_n && mem_ce_n) |-> !req_ready); // R6
    AST_SLEEP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> (!mem_oe_rfsh_n && mem_ce_n && !req_ready)); // R7
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_rfsh_n |-> !mem_dq_oe); // R10

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .AW        (AW),
    .DW        (DW),
    .T_POWERUP (T_POWERUP),
    .T_CYCLE   (T_CYCLE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .sleep_active  (sleep_active),
    .mem_addr      (mem_addr),
    .mem_dq_out    (mem_dq_out),
    .mem_dq_oe     (mem_dq_oe),
    .mem_ce_n      (mem_ce_n),
    .mem_rw_n      (mem_rw_n),
    .mem_oe_rfsh_n (mem_oe_rfsh_n)
);

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

    localparam int PU   = 20;
    localparam int SET  = 2;
    localparam int ACC  = 4;
    localparam int CYC  = 9;
    localparam int WRP  = 3;
    localparam int AUTO = 2;
    localparam int GAP  = 4;
    localparam int SMIN = 12;
    localparam int REC  = 10;
    localparam int IVL  = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, sleep_active;
    logic [7:0]  rsp_rdata;
    logic        sleep_req = 1'b0;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_ce_n, mem_rw_n, mem_oe_rfsh_n;

    always #5 clk = ~clk;

    psram_ctrl #(
        .T_POWERUP(PU), .T_ADDR_SETUP(SET), .T_ACCESS(ACC), .T_CYCLE(CYC),
        .T_WR_PULSE(WRP), .T_AUTO_PULSE(AUTO), .T_REF_GAP(GAP),
        .T_SELF_MIN(SMIN), .T_RECOVER(REC), .T_REFRESH_INTERVAL(IVL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sleep_req(sleep_req),
        .sleep_active(sleep_active), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
        .mem_rw_n(mem_rw_n), .mem_oe_rfsh_n(mem_oe_rfsh_n)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- memory model and pin monitor ----------------
    logic [7:0]  model [logic [18:0]];
    logic [18:0] lat_addr = '0, last_addr = '0;
    bit   prev_ce = 1'b1, prev_rw = 1'b1, prev_oe = 1'b1;
    bit   addr_moved = 1'b0, rdy_in_ref = 1'b0, last_was_self = 1'b0;
    int   ce_low = 0, since_fall = 1000, addr_stab = 0, oe_run = 0;
    int   since_oe_rise = 1000, ref_pulses = 0;

    initial mem_dq_in = 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            addr_stab = (mem_addr == last_addr) ? addr_stab + 1 : 1;
            last_addr = mem_addr;
            since_fall++;
            since_oe_rise++;
            if (prev_ce && !mem_ce_n) begin
                lat_addr = mem_addr;
                addr_moved = 1'b0;
                check(addr_stab - 1 >= SET, "R2 addr setup", addr_stab - 1, SET);
                check(since_fall >= CYC, "R4 cycle time", since_fall, CYC);
                if (last_was_self)
                    check(since_oe_rise >= REC, "R8 recovery", since_oe_rise, REC);
                since_fall = 1;
                ce_low = 0;
            end
            if (!mem_ce_n) begin
                ce_low++;
                if (mem_addr != lat_addr) addr_moved = 1'b1;
            end
            if (!prev_ce && mem_ce_n) begin
                check(!addr_moved, "R2 addr hold", addr_moved, 0);
                check(prev_rw, "R3 rw rises before ce", prev_rw, 1);
            end
            if (!prev_rw && mem_rw_n && !mem_ce_n) begin
                check(mem_dq_oe, "R3 data driven at rw edge", mem_dq_oe, 1);
                model[lat_addr] = mem_dq_out;
            end
            if (!mem_oe_rfsh_n && mem_ce_n) begin
                oe_run++;
                if (req_ready) rdy_in_ref = 1'b1;
            end
            if (!prev_oe && mem_oe_rfsh_n && prev_ce) begin
                check(!rdy_in_ref, "R6 ready low during refresh", rdy_in_ref, 0);
                if (oe_run < SMIN) begin
                    check(oe_run == AUTO, "R5 auto pulse width", oe_run, AUTO);
                    ref_pulses++;
                    last_was_self = 1'b0;
                end else begin
                    last_was_self = 1'b1;
                end
                since_oe_rise = 0;
                oe_run = 0;
                rdy_in_ref = 1'b0;
            end
            if (!mem_ce_n && mem_rw_n && !mem_oe_rfsh_n && ce_low >= ACC + 1)
                mem_dq_in = model.exists(lat_addr) ? model[lat_addr] : 8'h00;
            else
                mem_dq_in = 8'hEE;
            prev_ce = mem_ce_n;
            prev_rw = mem_rw_n;
            prev_oe = mem_oe_rfsh_n;
        end
    end

    // ---------------- host tasks ----------------
    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output bit got);
        int n = 0;
        got = 1'b0;
        rd  = '0;
        while (!req_ready && n < 2000) begin @(negedge clk); n++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready && n < 2000) begin
            if (rsp_valid) begin rd = rsp_rdata; got = 1'b1; end
            @(negedge clk); n++;
        end
    endtask

    // write flag, address, data (data is the expected value on reads)
    localparam logic [27:0] VEC [8] = '{
        {1'b1, 19'h00000, 8'hA5},
        {1'b1, 19'h7FFFF, 8'h3C},
        {1'b1, 19'h12345, 8'h81},
        {1'b0, 19'h00000, 8'hA5},
        {1'b0, 19'h7FFFF, 8'h3C},
        {1'b1, 19'h12345, 8'h7E},
        {1'b0, 19'h12345, 8'h7E},
        {1'b0, 19'h7FFFF, 8'h3C}
    };

    initial begin : main
        logic [7:0] rd;
        bit got, stray_ce;
        int n, p0;

        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_rw_n && mem_oe_rfsh_n && !mem_dq_oe && !req_ready,
              "R1 reset pins", {mem_ce_n, mem_rw_n, mem_oe_rfsh_n, mem_dq_oe, req_ready}, 5'b11100);
        rst_n = 1'b1;
        n = 0; stray_ce = 1'b0;
        while (!req_ready && n < 1000) begin
            @(negedge clk); n++;
            if (!mem_ce_n || !mem_oe_rfsh_n) stray_ce = 1'b1;
        end
        check(n >= PU && n <= PU + 1, "R1 powerup pause", n, PU);
        check(!stray_ce, "R1 pins quiet in pause", stray_ce, 0);

        for (int i = 0; i < 8; i++) begin
            do_req(VEC[i][27], VEC[i][26:8], VEC[i][7:0], rd, got);
            if (VEC[i][27]) begin
                check(model.exists(VEC[i][26:8]) && model[VEC[i][26:8]] == VEC[i][7:0],
                      "R3 write lands", model.exists(VEC[i][26:8]) ? model[VEC[i][26:8]] : 0, VEC[i][7:0]);
            end else begin
                check(got, "R2 rsp_valid seen", got, 1);
                check(rd == VEC[i][7:0], "R2 read data", rd, VEC[i][7:0]);
            end
        end

        // idle refresh rate
        p0 = ref_pulses;
        repeat (4 * IVL) @(negedge clk);
        check(ref_pulses - p0 >= 3 && ref_pulses - p0 <= 5, "R5 refresh count", ref_pulses - p0, 4);

        // refresh under continuous traffic
        p0 = ref_pulses;
        for (int i = 0; i < 30; i++) begin
            do_req(1'b0, 19'h7FFFF, 8'h00, rd, got);
            if (rd != 8'h3C) check(0, "R6 read under refresh", rd, 8'h3C);
        end
        check(ref_pulses - p0 >= 2, "R6 refresh interleaved", ref_pulses - p0, 2);

        // request arriving during a refresh pulse
        n = 0;
        while (!(!mem_oe_rfsh_n && mem_ce_n) && n < 500) begin @(negedge clk); n++; end
        check(!req_ready, "R6 stalled during pulse", req_ready, 0);
        do_req(1'b0, 19'h00000, 8'h00, rd, got);
        check(rd == 8'hA5, "R6 stalled read data", rd, 8'hA5);

        // self refresh
        p0 = ref_pulses;
        sleep_req = 1'b1;
        n = 0;
        while (!sleep_active && n < 500) begin @(negedge clk); n++; end
        check(sleep_active && oe_run >= SMIN, "R7 self entry width", oe_run, SMIN);
        stray_ce = 1'b0;
        repeat (5 * IVL) begin
            @(negedge clk);
            if (mem_oe_rfsh_n || !mem_ce_n || req_ready || !sleep_active) stray_ce = 1'b1;
        end
        check(!stray_ce, "R7 held in self refresh", stray_ce, 0);
        check(ref_pulses == p0, "R9 no auto refresh while asleep", ref_pulses - p0, 0);
        sleep_req = 1'b0;
        n = 0;
        while (!req_ready && n < 500) begin @(negedge clk); n++; end
        check(n >= REC, "R8 ready after recovery", n, REC);
        p0 = ref_pulses;
        n = 0;
        while (ref_pulses == p0 && n < 2 * IVL) begin @(negedge clk); n++; end
        check(n <= IVL + AUTO + 2, "R9 refresh resumes", n, IVL);
        do_req(1'b0, 19'h12345, 8'h00, rd, got);
        check(rd == 8'h7E, "R8 data after wake", rd, 8'h7E);

        check(1'b1, "R10 contention covered by property", 0, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

endmodule